// File: doc/BRIEF.md
# Transport Packet Sync Detector

This block watches a byte stream, qualified by a per-byte valid strobe, and recovers the packet framing of an error-protected transport stream. Its sync value is held in a writable register. A candidate sync word is either that value or its bitwise complement. The block tracks candidates at a fixed frame pitch. Once enough sync words have been confirmed, it drives alignment signals for the deinterleaver, outer decoder and descrambler that follow it. These signals are a one-cycle frame-start pulse, a byte index within the frame, a flag telling which polarity of sync word began the frame, and a lock status.

Every byte is forwarded with one cycle of latency, whatever the mode. Frame positions are counted in valid bytes only, so gaps in the strobe do not disturb the alignment. Lock hysteresis works in both directions. Several consecutive confirmed sync words are needed to lock. Several consecutive missing sync words are needed to unlock, and up to that point the block coasts on its own count. A bypass input passes the stream straight through and keeps every alignment output inactive.

Top module: `ts_sync_detect`

## Requirements
- R1: After reset, locked, frame_start, sync_inv, out_valid and byte_idx are all 0, and the sync register holds 0x47.
- R2: Each byte presented with in_valid high appears on out_data with out_valid high exactly one clock later. This holds in every mode, bypass included.
- R3: From hunting, locked rises in the output cycle of the third sync word found at a spacing of exactly 204 valid bytes. It does not rise after the second.
- R4: A byte equal to the sync register or to its bitwise complement (0xB8 for 0x47) counts as a sync word. On a frame start caused by the complement sync_inv is 1, and on one caused by the true value it is 0.
- R5: While locked, frame_start is a one-cycle pulse on the sync-position byte, with byte_idx 0 and that byte on out_data. The following bytes carry byte_idx 1 to 203 and frame_start 0.
- R6: While locked, up to three consecutive missed sync positions keep lock, and frame_start still pulses at those positions. A sync word found at a sync position clears the miss count. The fourth consecutive miss drops locked on that byte with no frame_start, and the block returns to hunting at every byte position.
- R7: During confirmation, a sync word at a spacing other than 204 is ignored. A non-sync byte at the expected position sends the block back to hunting, so no lock results.
- R8: A write with cfg_we loads cfg_sync into the sync register. Afterwards the new value and its complement are recognised and the old value is not.
- R9: While bypass is high, out_data still follows in_data. From the cycle after bypass is sampled high, locked, frame_start and byte_idx stay 0, and hunting restarts when bypass falls.
- R10: Cycles with in_valid low leave byte_idx and locked unchanged and produce no frame_start.
- R11: While not locked, byte_idx is 0 and frame_start is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the sync register |
| cfg_sync | input | 8 | New sync value |
| bypass | input | 1 | Pass data through with no alignment |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte, one cycle delayed |
| frame_start | output | 1 | Pulse on the sync-position byte while locked |
| byte_idx | output | $clog2(FRAME_LEN) (8) | Position of out_data in the frame while locked |
| sync_inv | output | 1 | Frame began with the complemented sync word |
| locked | output | 1 | Frame alignment established |

## Verification
The hardest condition to reach is the exact edge of the unlock hysteresis. Getting there takes a locked stream, then three missed sync positions, then a good one that must reset the miss count, then four more misses whose last one must drop lock on that very byte. The stimulus builds whole 204-byte frames. Payload bytes are random but exclude both sync polarities, and idle gaps are inserted at random. The bench chooses the byte at each sync slot, so miss sequences and wrong-spacing candidates are placed exactly while the gaps vary around them.

// File: rtl/ts_sync_detect.sv
module ts_sync_detect #(
  parameter int         FRAME_LEN   = 204,
  parameter int         LOCK_HITS   = 3,
  parameter int         DROP_MISSES = 4,
  parameter logic [7:0] SYNC_INIT   = 8'h47,
  localparam int        PW = $clog2(FRAME_LEN),
  localparam int        HW = $clog2(LOCK_HITS + 1),
  localparam int        MW = $clog2(DROP_MISSES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_sync,
  input  logic          bypass,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          frame_start,
  output logic [PW-1:0] byte_idx,
  output logic          sync_inv,
  output logic          locked
);

  typedef enum logic [1:0] {S_HUNT, S_CHECK, S_LOCK} st_t;

  st_t           st;
  logic [7:0]    sync_q;
  logic [PW-1:0] pos;
  logic [HW-1:0] hits;
  logic [MW-1:0] miss;

  wire is_true = (in_data == sync_q);
  wire is_comp = (in_data == ~sync_q);
  wire hit     = is_true | is_comp;
  wire at_slot = (pos == PW'(FRAME_LEN - 1));
  wire [PW-1:0] pos_nxt = at_slot ? '0 : pos + 1'b1;

  assign locked = (st == S_LOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_HUNT;
      sync_q      <= SYNC_INIT;
      pos         <= '0;
      hits        <= '0;
      miss        <= '0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      frame_start <= 1'b0;
      byte_idx    <= '0;
      sync_inv    <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      frame_start <= 1'b0;
      if (in_valid) out_data <= in_data;
      if (cfg_we) sync_q <= cfg_sync;

      if (bypass) begin
        st       <= S_HUNT;
        hits     <= '0;
        miss     <= '0;
        byte_idx <= '0;
        sync_inv <= 1'b0;
      end else if (in_valid) begin
        unique case (st)
          S_HUNT: begin
            if (hit) begin
              st   <= S_CHECK;
              pos  <= '0;
              hits <= HW'(1);
            end
          end
          S_CHECK: begin
            pos <= pos_nxt;
            if (at_slot) begin
              if (!hit) begin
                st <= S_HUNT;
              end else if (hits + 1'b1 == HW'(LOCK_HITS)) begin
                st          <= S_LOCK;
                miss        <= '0;
                frame_start <= 1'b1;
                byte_idx    <= '0;
                sync_inv    <= is_comp;
              end else begin
                hits <= hits + 1'b1;
              end
            end
          end
          S_LOCK: begin
            pos      <= pos_nxt;
            byte_idx <= pos_nxt;
            if (at_slot) begin
              if (hit) begin
                miss        <= '0;
                frame_start <= 1'b1;
                sync_inv    <= is_comp;
              end else if (miss == MW'(DROP_MISSES - 1)) begin
                st       <= S_HUNT;
                hits     <= '0;
                byte_idx <= '0;
                sync_inv <= 1'b0;
              end else begin
                miss        <= miss + 1'b1;
                frame_start <= 1'b1;
                sync_inv    <= 1'b0;
              end
            end
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end

endmodule

// File: rtl/ts_sync_detect_chk.sv
module ts_sync_detect_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bypass,
  input logic          in_valid,
  input logic [7:0]    in_data,
  input logic          out_valid,
  input logic [7:0]    out_data,
  input logic          frame_start,
  input logic [PW-1:0] byte_idx,
  input logic          locked
);

  p_pass_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid && out_data == $past(in_data));

  p_start_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> locked && out_valid && byte_idx == '0);

  p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  p_lock_rises_at_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> frame_start);

  p_bypass_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> !locked && !frame_start && byte_idx == '0);

  p_gap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !bypass |=> $stable(byte_idx) && $stable(locked) && !frame_start);

  p_unlocked_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> byte_idx == '0 && !frame_start);

endmodule

bind ts_sync_detect ts_sync_detect_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass), .in_valid(in_valid),
  .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
  .frame_start(frame_start), .byte_idx(byte_idx), .locked(locked)
);

// File: tb/ts_sync_detect_test.sv
`timescale 1ns/1ps
module ts_sync_detect_test;
  localparam int FL = 204;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_sync = 8'h00;
  logic       bypass = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_valid, frame_start, sync_inv, locked;
  logic [7:0] out_data, byte_idx;

  int checks = 0;
  int errors = 0;
  logic [7:0] cur_sync = 8'h47;

  always #2.5 clk = ~clk;

  ts_sync_detect uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sync(cfg_sync),
    .bypass(bypass), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .frame_start(frame_start),
    .byte_idx(byte_idx), .sync_inv(sync_inv), .locked(locked)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pay();
    logic [7:0] b;
    do b = 8'($urandom); while (b == cur_sync || b == ~cur_sync);
    return b;
  endfunction

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    check("R2", "out_valid", int'(out_valid), 1);
    check("R2", "out_data", int'(out_data), int'(b));
  endtask

  task automatic gap();
    int prev_idx, prev_lk;
    if ($urandom % 6 == 0) begin
      prev_idx = int'(byte_idx);
      prev_lk  = int'(locked);
      @(posedge clk);
      #1;
      check("R10", "out_valid in gap", int'(out_valid), 0);
      check("R10", "byte_idx in gap", int'(byte_idx), prev_idx);
      check("R10", "locked in gap", int'(locked), prev_lk);
      check("R10", "frame_start in gap", int'(frame_start), 0);
    end
  endtask

  task automatic send_frame(input logic [7:0] s, input bit lk, input bit fs,
                            input bit inv, input string tag);
    put(s);
    check(tag, "locked at slot", int'(locked), int'(lk));
    check(tag, "frame_start at slot", int'(frame_start), int'(fs));
    check(tag, "byte_idx at slot", int'(byte_idx), 0);
    if (fs) check(tag, "sync_inv", int'(sync_inv), int'(inv));
    gap();
    for (int i = 1; i < FL; i++) begin
      put(pay());
      check("R5", "frame_start mid frame", int'(frame_start), 0);
      check(lk ? "R5" : "R11", "byte_idx", int'(byte_idx), lk ? i : 0);
      gap();
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R1", "locked", int'(locked), 0);
    check("R1", "frame_start", int'(frame_start), 0);
    check("R1", "byte_idx", int'(byte_idx), 0);
    check("R1", "out_valid", int'(out_valid), 0);
    check("R1", "sync_inv", int'(sync_inv), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 40; i++) begin
      put(pay());
      check("R11", "locked while hunting", int'(locked), 0);
      check("R11", "byte_idx while hunting", int'(byte_idx), 0);
      gap();
    end

    send_frame(8'h47, 0, 0, 0, "R3");
    send_frame(8'hB8, 0, 0, 0, "R4");
    send_frame(8'h47, 1, 1, 0, "R3");
    send_frame(8'hB8, 1, 1, 1, "R4");
    send_frame(8'h47, 1, 1, 0, "R4");

    for (int k = 0; k < 3; k++) send_frame(8'h00, 1, 1, 0, "R6");
    send_frame(8'h47, 1, 1, 0, "R6");
    for (int k = 0; k < 3; k++) send_frame(8'h12, 1, 1, 0, "R6");
    send_frame(8'h12, 0, 0, 0, "R6");

    put(8'h47);
    check("R7", "locked after candidate", int'(locked), 0);
    for (int i = 0; i < 150; i++) put(pay());
    put(8'hB8);
    for (int i = 0; i < 52; i++) put(pay());
    put(pay());
    check("R7", "locked after wrong spacing", int'(locked), 0);
    send_frame(8'h47, 0, 0, 0, "R7");
    send_frame(8'h47, 0, 0, 0, "R7");
    send_frame(8'h47, 1, 1, 0, "R7");

    @(negedge clk);
    bypass = 1'b1;
    put(8'h47);
    check("R9", "locked in bypass", int'(locked), 0);
    check("R9", "frame_start in bypass", int'(frame_start), 0);
    check("R9", "byte_idx in bypass", int'(byte_idx), 0);
    for (int i = 0; i < 2 * FL + 3; i++) begin
      put((i % FL == 0) ? 8'h47 : pay());
      check("R9", "locked in bypass", int'(locked), 0);
      check("R9", "frame_start in bypass", int'(frame_start), 0);
    end
    @(negedge clk);
    bypass = 1'b0;
    send_frame(8'hB8, 0, 0, 0, "R9");
    send_frame(8'h47, 0, 0, 0, "R9");
    send_frame(8'h47, 1, 1, 0, "R9");

    @(negedge clk);
    bypass = 1'b1;
    @(negedge clk);
    bypass   = 1'b0;
    cfg_we   = 1'b1;
    cfg_sync = 8'h1D;
    @(negedge clk);
    cfg_we   = 1'b0;
    cur_sync = 8'h1D;
    send_frame(8'h47, 0, 0, 0, "R8");
    send_frame(8'h47, 0, 0, 0, "R8");
    send_frame(8'h47, 0, 0, 0, "R8");
    send_frame(8'hE2, 0, 0, 0, "R8");
    send_frame(8'h1D, 0, 0, 0, "R8");
    send_frame(8'hE2, 1, 1, 1, "R8");
    send_frame(8'h1D, 1, 1, 0, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule